// File: doc/BRIEF.md
# Byte-Lane Access Splitter

This block sits between a processor's load/store port and a data bus built from four byte-wide banks. The requester asks for one, two or four bytes starting at any byte address. The block turns that request into as many aligned bus cycles as the operand needs. For each cycle it drives an active-low enable per bank and places each write byte on the lane its address selects. On reads it collects the bytes returned on the lanes into a right-justified little-endian result. The requester never sees the split. It gets one completion pulse after the last bus cycle has finished.

A mode input selects between the full four-lane bus and a narrow bus that uses only lanes 0 and 1. The mode is sampled when a request is accepted, so it can change between operations. In narrow mode the bus moves two bytes per cycle. A four-byte operand that starts at an odd address therefore needs three cycles. The bus handshake is a request held until a ready is sampled.

Top module: `lane_split_top`

## Requirements
- R1: After reset, bus_req and req_done are low, req_ready is high and all four bus_be_n bits are high.
- R2: req_size 2'b00 means one byte, 2'b01 two bytes, and 2'b10 or 2'b11 four bytes; req_addr may hold any byte address.
- R3: In wide mode (req_narrow=0), an operand whose bytes all fall in one aligned 4-byte group is done in exactly one bus cycle, and bus_addr always has its low two bits at zero.
- R4: One bus cycle is issued for each aligned group the operand touches, in ascending address order, with each bus_addr one group size above the one before.
- R5: bus_be_n[i] is low in a bus cycle exactly when the byte at bus_addr+i belongs to the operand; memory bytes outside the operand are never written.
- R6: Operand write byte k (bits 8k+7..8k of req_wdata, little-endian) is driven on the lane of address req_addr+k, in the cycle that covers that address.
- R7: A read result has byte k equal to the memory byte at req_addr+k, with unused upper bytes zero. It is valid on req_rdata in the cycle req_done is high, and only after the final bus cycle.
- R8: With req_narrow=1 at acceptance, groups are 2 bytes, bus_addr bit 0 is zero, bus_be_n[3:2] stay high, data on lanes 2 and 3 is ignored, and up to three cycles may be issued.
- R9: bus_req, bus_addr, bus_be_n, bus_we and bus_wdata stay unchanged until bus_rdy is sampled high on a rising clock edge, which completes that cycle.
- R10: req_ready is high only while idle. req_valid has no effect while busy. req_done is a one-cycle pulse in the cycle after the last bus cycle completes, and req_ready is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Operand size code |
| req_addr | input | ADDR_W | Byte address of the operand's lowest byte |
| req_wdata | input | 32 | Store data, right-justified |
| req_narrow | input | 1 | 1 = use the 16-bit bus for this operation |
| req_done | output | 1 | Operation complete pulse |
| req_rdata | output | 32 | Load result, right-justified, zero-extended |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | ADDR_W | Aligned group address |
| bus_be_n | output | 4 | Active-low bank enables, bit i = lane i |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_rdata | input | 32 | Read data from the banks |
| bus_rdy | input | 1 | Bus cycle completion |

## Verification
The bench goes after operands that straddle a group boundary at every start offset. A splitter that gets this wrong issues one cycle too few, or drops the high bytes, or merges them onto the wrong lanes. It switches the bus mode between operations and uses a four-byte operand at an odd address in narrow mode. That case needs three cycles, and a design with a fixed two-cycle limit would truncate it. During narrow reads the bench puts garbage on lanes 2 and 3 and adds wait states, so a design that reads those lanes or moves on before ready returns corrupted results. It also compares the whole memory image after each store, to catch enables leaking onto neighbouring bytes. It raises req_valid while the block is busy, to catch a design that starts an extra operation.

// File: rtl/lane_split_pkg.sv
package lane_split_pkg;
  localparam int NUM_LANES  = 4;
  localparam int LANE_BITS  = 8;
  localparam int DATA_BITS  = NUM_LANES * LANE_BITS;
  localparam int LANE_IDX_W = $clog2(NUM_LANES);
  localparam int LEN_W      = LANE_IDX_W + 1;
  localparam int CYC_W      = LANE_IDX_W;
  localparam int OFF_W      = LANE_IDX_W + 3;

  typedef enum logic [1:0] {
    SZ_ONE  = 2'b00,
    SZ_TWO  = 2'b01,
    SZ_FOUR = 2'b10,
    SZ_ALT4 = 2'b11
  } op_size_e;

  // Number of bytes in an operand of the given size code.
  function automatic int op_bytes(input logic [1:0] sz);
    case (sz)
      SZ_ONE:  return 1;
      SZ_TWO:  return 2;
      default: return NUM_LANES;
    endcase
  endfunction

  // Bytes moved by one bus cycle in the chosen bus width.
  function automatic int group_bytes(input logic narrow);
    return narrow ? NUM_LANES / 2 : NUM_LANES;
  endfunction

  // Bus cycles needed for an operand starting at lane start_lane.
  function automatic int cycle_total(input int start_lane, input int nbytes, input int grp);
    return (start_lane + nbytes - 1) / grp + 1;
  endfunction

  // Operand byte index carried by a lane in a given cycle (may be negative).
  function automatic int byte_of_lane(input int cyc, input int lane, input int start_lane,
                                      input int grp);
    return cyc * grp + lane - start_lane;
  endfunction
endpackage

// File: rtl/lane_steer.sv
module lane_steer
  import lane_split_pkg::*;
(
  input  logic [LANE_IDX_W-1:0]                 op_start,
  input  logic [LEN_W-1:0]                      op_len,
  input  logic                                  op_narrow,
  input  logic [CYC_W-1:0]                      cyc_idx,
  input  logic [DATA_BITS-1:0]                  op_wdata,
  output logic [NUM_LANES-1:0]                  lane_act,
  output logic [NUM_LANES-1:0][LANE_IDX_W-1:0]  lane_pick,
  output logic [DATA_BITS-1:0]                  lane_wdata
);
  int grp;
  assign grp = group_bytes(op_narrow);

  for (genvar L = 0; L < NUM_LANES; L++) begin : g_lane
    logic signed [OFF_W-1:0] rel;
    logic [OFF_W-2:0]        rel_mag;
    logic                    in_grp;

    assign rel     = OFF_W'(byte_of_lane(int'(cyc_idx), L, int'(op_start), grp));
    assign rel_mag = rel[OFF_W-2:0];
    assign in_grp  = (L < grp);
    assign lane_act[L]  = in_grp && !rel[OFF_W-1] && (rel_mag < (OFF_W-1)'(op_len));
    assign lane_pick[L] = rel_mag[LANE_IDX_W-1:0];
    assign lane_wdata[L*LANE_BITS +: LANE_BITS] =
      lane_act[L] ? op_wdata[rel_mag[LANE_IDX_W-1:0]*LANE_BITS +: LANE_BITS] : '0;
  end
endmodule

// File: rtl/rd_gather.sv
module rd_gather
  import lane_split_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 clr,
  input  logic                                 cap,
  input  logic [NUM_LANES-1:0]                 lane_act,
  input  logic [NUM_LANES-1:0][LANE_IDX_W-1:0] lane_pick,
  input  logic [DATA_BITS-1:0]                 bus_rdata,
  output logic [DATA_BITS-1:0]                 acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (clr) begin
      acc <= '0;
    end else if (cap) begin
      for (int L = 0; L < NUM_LANES; L++) begin
        if (lane_act[L])
          acc[lane_pick[L]*LANE_BITS +: LANE_BITS] <= bus_rdata[L*LANE_BITS +: LANE_BITS];
      end
    end
  end

  // R7
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !cap |=> $stable(acc));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import lane_split_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [1:0]            req_size,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_BITS-1:0]  req_wdata,
  input  logic                  req_narrow,
  input  logic                  bus_rdy,
  output logic                  req_ready,
  output logic                  req_done,
  output logic                  bus_req,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic                  op_write,
  output logic [DATA_BITS-1:0]  op_wdata,
  output logic [LANE_IDX_W-1:0] op_start,
  output logic [LEN_W-1:0]      op_len,
  output logic                  op_narrow,
  output logic [CYC_W-1:0]      cyc_idx,
  output logic                  accept,
  output logic                  cyc_fire,
  output logic                  cyc_last
);
  typedef enum logic {ST_IDLE, ST_BUS} st_e;
  st_e state;

  logic [ADDR_W-1:0] op_addr;
  logic [CYC_W-1:0]  cyc_max;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] base;
  logic [LANE_IDX_W-1:0] new_start;
  int new_grp;
  int new_len;

  assign req_ready = (state == ST_IDLE);
  assign bus_req   = (state == ST_BUS);
  assign accept    = req_ready && req_valid;
  assign cyc_fire  = bus_req && bus_rdy;
  assign cyc_last  = (cyc_idx == cyc_max);

  assign new_grp   = group_bytes(req_narrow);
  assign new_len   = op_bytes(req_size);
  assign new_start = req_addr[LANE_IDX_W-1:0] & LANE_IDX_W'(new_grp - 1);

  assign step     = op_narrow ? ADDR_W'(NUM_LANES / 2) : ADDR_W'(NUM_LANES);
  assign base     = op_addr & ~(step - ADDR_W'(1));
  assign bus_addr = base + step * ADDR_W'(cyc_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      req_done  <= 1'b0;
      op_addr   <= '0;
      op_write  <= 1'b0;
      op_wdata  <= '0;
      op_start  <= '0;
      op_len    <= '0;
      op_narrow <= 1'b0;
      cyc_idx   <= '0;
      cyc_max   <= '0;
    end else begin
      req_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            op_addr   <= req_addr;
            op_write  <= req_write;
            op_wdata  <= req_wdata;
            op_narrow <= req_narrow;
            op_start  <= new_start;
            op_len    <= LEN_W'(new_len);
            cyc_idx   <= '0;
            cyc_max   <= CYC_W'(cycle_total(int'(new_start), new_len, new_grp) - 1);
            state     <= ST_BUS;
          end
        end
        default: begin
          if (bus_rdy) begin
            if (cyc_last) begin
              state    <= ST_IDLE;
              req_done <= 1'b1;
            end else begin
              cyc_idx <= cyc_idx + CYC_W'(1);
            end
          end
        end
      endcase
    end
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_rdy |=> bus_req && $stable(bus_addr) && $stable(op_write));
  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_fire && !cyc_last |=> bus_req && (bus_addr == $past(bus_addr) + $past(step)));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);
  // R10
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_fire && cyc_last |=> req_done && req_ready);
  // R3
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_addr & (step - ADDR_W'(1))) == '0);
endmodule

// File: rtl/lane_split_top.sv
module lane_split_top
  import lane_split_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [1:0]           req_size,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_BITS-1:0] req_wdata,
  input  logic                 req_narrow,
  output logic                 req_done,
  output logic [DATA_BITS-1:0] req_rdata,
  output logic                 bus_req,
  output logic                 bus_we,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [NUM_LANES-1:0] bus_be_n,
  output logic [DATA_BITS-1:0] bus_wdata,
  input  logic [DATA_BITS-1:0] bus_rdata,
  input  logic                 bus_rdy
);
  logic                                 op_write;
  logic [DATA_BITS-1:0]                 op_wdata;
  logic [LANE_IDX_W-1:0]                op_start;
  logic [LEN_W-1:0]                     op_len;
  logic                                 op_narrow;
  logic [CYC_W-1:0]                     cyc_idx;
  logic                                 accept;
  logic                                 cyc_fire;
  logic                                 cyc_last;
  logic [NUM_LANES-1:0]                 lane_act;
  logic [NUM_LANES-1:0][LANE_IDX_W-1:0] lane_pick;
  logic [DATA_BITS-1:0]                 lane_wdata;
  logic                                 rd_cap;

  seq_ctrl #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_narrow(req_narrow), .bus_rdy(bus_rdy), .req_ready(req_ready),
    .req_done(req_done), .bus_req(bus_req), .bus_addr(bus_addr),
    .op_write(op_write), .op_wdata(op_wdata), .op_start(op_start),
    .op_len(op_len), .op_narrow(op_narrow), .cyc_idx(cyc_idx),
    .accept(accept), .cyc_fire(cyc_fire), .cyc_last(cyc_last)
  );

  lane_steer u_steer (
    .op_start(op_start), .op_len(op_len), .op_narrow(op_narrow),
    .cyc_idx(cyc_idx), .op_wdata(op_wdata), .lane_act(lane_act),
    .lane_pick(lane_pick), .lane_wdata(lane_wdata)
  );

  assign rd_cap = cyc_fire && !op_write;

  rd_gather u_gather (
    .clk(clk), .rst_n(rst_n), .clr(accept), .cap(rd_cap),
    .lane_act(lane_act), .lane_pick(lane_pick), .bus_rdata(bus_rdata),
    .acc(req_rdata)
  );

  assign bus_we    = bus_req && op_write;
  assign bus_be_n  = bus_req ? ~lane_act : '1;
  assign bus_wdata = bus_we ? lane_wdata : '0;

  // R5
  some_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_be_n != '1);
  // R8
  narrow_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && op_narrow |-> bus_be_n[NUM_LANES-1:NUM_LANES/2] == '1);
  // R1
  idle_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> bus_be_n == '1 && !bus_we);
endmodule

// File: tb/lane_split_tb.sv
`timescale 1ns/1ps
module lane_split_top_tb_top;
  localparam int AW = 32;
  localparam logic [31:0] BASE = 32'h4000_0000;

  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic [7:0]  off;
    logic        m16;
    logic [31:0] wd;
    logic [1:0]  cyc;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd2, 8'h10, 1'b0, 32'hA1B2C3D4, 2'd1},
    '{1'b0, 2'd2, 8'h10, 1'b0, 32'h0,        2'd1},
    '{1'b1, 2'd1, 8'h13, 1'b0, 32'h00005A6B, 2'd2},
    '{1'b0, 2'd1, 8'h13, 1'b0, 32'h0,        2'd2},
    '{1'b1, 2'd2, 8'h21, 1'b0, 32'h11223344, 2'd2},
    '{1'b0, 2'd2, 8'h21, 1'b0, 32'h0,        2'd2},
    '{1'b0, 2'd0, 8'h07, 1'b0, 32'h0,        2'd1},
    '{1'b1, 2'd2, 8'h29, 1'b1, 32'hCAFEF00D, 2'd3},
    '{1'b0, 2'd2, 8'h29, 1'b1, 32'h0,        2'd3},
    '{1'b0, 2'd1, 8'h06, 1'b1, 32'h0,        2'd1},
    '{1'b1, 2'd0, 8'h33, 1'b1, 32'h0000009C, 2'd1},
    '{1'b0, 2'd1, 8'h33, 1'b1, 32'h0,        2'd2},
    '{1'b0, 2'd2, 8'h0C, 1'b1, 32'h0,        2'd2},
    '{1'b0, 2'd1, 8'h1E, 1'b0, 32'h0,        2'd1},
    '{1'b0, 2'd2, 8'h3B, 1'b0, 32'h0,        2'd2},
    '{1'b0, 2'd3, 8'h22, 1'b0, 32'h0,        2'd2},
    '{1'b1, 2'd1, 8'h3D, 1'b1, 32'h0000E7D8, 2'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_narrow = 1'b0;
  logic [1:0] req_size = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, req_done, bus_req, bus_we;
  logic [31:0] req_rdata, bus_wdata;
  logic [AW-1:0] bus_addr;
  logic [3:0] bus_be_n;
  logic [31:0] bus_rdata = '0;
  logic bus_rdy = 1'b0;

  always #2 clk = ~clk;

  lane_split_top #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_narrow(req_narrow), .req_done(req_done),
    .req_rdata(req_rdata), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be_n(bus_be_n), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdy(bus_rdy)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] mem [64];
  logic [7:0] snap [64];
  logic [31:0] log_addr [4];
  logic [3:0]  log_be [4];
  int n_serve = 0;
  int rdy_delay = 0;
  bit narrow_now = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bus responder: memory model with wait states, garbage on upper lanes in narrow mode
  initial begin
    int cnt = 0;
    bit seen = 1'b0;
    logic [31:0] hold_addr = '0;
    logic [3:0]  hold_be = '0;
    logic [31:0] hold_wd = '0;
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 13 + 5);
    forever begin
      @(negedge clk);
      if (bus_rdy) begin
        bus_rdy = 1'b0;
        cnt = rdy_delay;
        seen = 1'b0;
      end else if (bus_req) begin
        if (!seen) begin
          seen = 1'b1;
          hold_addr = bus_addr; hold_be = bus_be_n; hold_wd = bus_wdata;
        end
        if (cnt == 0) begin
          // R9: cycle held unchanged through wait states
          chk(hold_addr == bus_addr && hold_be == bus_be_n && hold_wd == bus_wdata,
              "R9 hold", {bus_addr, bus_wdata}, {hold_addr, hold_wd});
          if (n_serve < 4) begin
            log_addr[n_serve] = bus_addr;
            log_be[n_serve] = bus_be_n;
          end
          n_serve++;
          for (int L = 0; L < 4; L++) begin
            if (bus_we) begin
              if (!bus_be_n[L]) mem[6'(bus_addr[5:0] + 6'(L))] = bus_wdata[L*8 +: 8];
            end else begin
              bus_rdata[L*8 +: 8] = (narrow_now && L >= 2) ? 8'hEE
                                    : mem[6'(bus_addr[5:0] + 6'(L))];
            end
          end
          bus_rdy = 1'b1;
        end else begin
          cnt--;
        end
      end
    end
  end

  task automatic run_vec(input int i, input vec_t v);
    int n, g, guard;
    logic [31:0] a, exp_rd, gb;
    logic [3:0] exp_be;
    logic [7:0] exp_mem [64];
    bit mem_ok;
    n = (v.sz == 2'd0) ? 1 : (v.sz == 2'd1) ? 2 : 4;
    g = v.m16 ? 2 : 4;
    a = BASE + 32'(v.off);
    for (int k = 0; k < 64; k++) snap[k] = mem[k];
    rdy_delay = i % 3;
    n_serve = 0;
    narrow_now = v.m16;
    @(negedge clk);
    req_valid = 1'b1; req_write = v.we; req_size = v.sz; req_addr = a;
    req_wdata = v.wd; req_narrow = v.m16;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, $sformatf("R10 ready low busy v%0d", i), 64'(req_ready), 64'd0);
    guard = 0;
    while (!req_done && guard < 300) begin @(negedge clk); guard++; end
    chk(req_done, $sformatf("R10 done seen v%0d", i), 64'(req_done), 64'd1);
    chk(req_ready, $sformatf("R10 ready at done v%0d", i), 64'(req_ready), 64'd1);
    if (!v.we) begin
      exp_rd = '0;
      for (int k = 0; k < n; k++) exp_rd[k*8 +: 8] = snap[6'(v.off + 8'(k))];
      // R7 / R2: right-justified little-endian, zero upper bytes
      chk(req_rdata == exp_rd, $sformatf("R7 rdata v%0d", i), 64'(req_rdata), 64'(exp_rd));
    end
    @(negedge clk);
    chk(!req_done, $sformatf("R10 done pulse v%0d", i), 64'(req_done), 64'd0);
    // R3 / R4 / R8: cycle count
    chk(n_serve == int'(v.cyc), $sformatf("R4 cycles v%0d", i), 64'(n_serve), 64'(v.cyc));
    for (int j = 0; j < int'(v.cyc) && j < n_serve; j++) begin
      gb = (a / 32'(g) + 32'(j)) * 32'(g);
      exp_be = 4'hF;
      for (int L = 0; L < g; L++)
        if (gb + 32'(L) >= a && gb + 32'(L) < a + 32'(n)) exp_be[L] = 1'b0;
      chk(log_addr[j] == gb, $sformatf("R4 addr v%0d c%0d", i, j), 64'(log_addr[j]), 64'(gb));
      chk(log_be[j] == exp_be, $sformatf("R5 R8 be_n v%0d c%0d", i, j),
          64'(log_be[j]), 64'(exp_be));
    end
    for (int k = 0; k < 64; k++) exp_mem[k] = snap[k];
    if (v.we)
      for (int k = 0; k < n; k++) exp_mem[6'(v.off + 8'(k))] = v.wd[k*8 +: 8];
    mem_ok = 1'b1;
    for (int k = 0; k < 64; k++) if (mem[k] != exp_mem[k]) mem_ok = 1'b0;
    // R6: bytes on right lanes; R5: neighbours untouched
    chk(mem_ok, $sformatf("R6 R5 memory image v%0d", i),
        {mem[6'(v.off)], mem[6'(v.off + 8'd1)]}, {exp_mem[6'(v.off)], exp_mem[6'(v.off + 8'd1)]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int guard;
    logic [7:0] m0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!bus_req, "R1 bus_req", 64'(bus_req), 64'd0);
    chk(req_ready, "R1 req_ready", 64'(req_ready), 64'd1);
    chk(!req_done, "R1 req_done", 64'(req_done), 64'd0);
    chk(bus_be_n == 4'hF, "R1 be_n", 64'(bus_be_n), 64'hF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(i, VECS[i]);

    // R10: req_valid while busy is ignored
    m0 = mem[0];
    rdy_delay = 2; n_serve = 0; narrow_now = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_addr = BASE + 32'h21;
    req_narrow = 1'b0;
    @(negedge clk);
    req_write = 1'b1; req_size = 2'd0; req_addr = BASE; req_wdata = 32'h77;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!req_done && guard < 300) begin @(negedge clk); guard++; end
    repeat (6) @(negedge clk);
    chk(n_serve == 2, "R10 busy request ignored cycles", 64'(n_serve), 64'd2);
    chk(!bus_req, "R10 no extra op", 64'(bus_req), 64'd0);
    chk(mem[0] == m0, "R10 no extra write", 64'(mem[0]), 64'(m0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule